// File: doc/BRIEF.md
# Multi-Rate Walsh Spreading Encoder

This block turns two serial streams into one chip stream for a QPSK modulator. Payload data arrives as 4-bit symbols through a ready/valid handshake. Each symbol picks one of 16 Walsh codewords, and the codeword chips go on the Q branch. A control stream supplies one sync bit per frame. That bit is spread on the I branch by a 64-chip pilot sequence, built from a 63-chip maximal-length sequence with one zero chip added. The output carries one chip per clock. I and Q alternate, with the I chip first in each chip slot.

A data frame spans 64 chip slots. In the slow rate, one 64-chip codeword fills the frame. In the fast rate, two 32-chip codewords for consecutive symbols share the frame: the first fills slots 0 to 31 and the second fills slots 32 to 63. Before the first frame, the I branch sends a fixed 80-slot preamble, and a flag stays high for the data source while the preamble runs. Each chip comes from a lookup over the index {rate, sync bit, symbol, chip slot}. No multiplier is used.

A synchronous reset sends the encoder back to the start of the preamble.

Top module: `walsh_spread_enc`

## Requirements
- R1: While `rst` is high, `preambleOn` is 1 and `chipIsQ`, `chipOut` and `symReady` are all 0. The first cycle after `rst` is released presents preamble slot 0 as an I chip.
- R2: `chipIsQ` alternates every cycle, starting at 0. A chip slot is two cycles: the I chip comes first, then the Q chip.
- R3: The preamble lasts 80 slots, and `preambleOn` is 1 for exactly those 160 cycles. In slots 0 to 31 the I chip equals the slot number's LSB (0,1,0,1,...). In slots 32 to 79 the I chip is bit 79−slot of the word 48'hF3A6_0D957C21, so the word goes out MSB first. Every Q chip in the preamble is 0.
- R4: In data slot k (0..63), the I chip is the latched sync bit XOR m[k]. For k ≤ 62, m[k] is bit 5 of a 6-bit register. That register is set to 6'h3F at each frame start and advances as s ← {s[4:0], s[5]^s[4]} after each slot. m[63] is 0.
- R5: In the slow rate (latched rate 0), the Q chip of slot k is the parity of (symbol AND k[5:2]).
- R6: In the fast rate (latched rate 1), the Q chip of slot k is the parity of (symbol AND k[4:1]). The symbol used in slots 32..63 is the one accepted at the middle of the frame, not the one used in slots 0..31.
- R7: `symReady` is 1 only in the Q cycle of the last slot of a codeword: preamble slot 79, frame slot 63, and, in the fast rate, frame slot 31. On that clock edge the symbol becomes `symData` if `symValid` is 1, and 0 otherwise.
- R8: `rateSel` and `syncIn` are sampled only on the clock edge that closes the preamble or a frame. Changes to them at any other time do not affect the chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rateSel | input | 1 | Rate select: 1 = 32-chip codewords, 0 = 64-chip codewords |
| syncIn | input | 1 | Sync-control bit for the next frame |
| symValid | input | 1 | A symbol is offered on `symData` |
| symData | input | 4 | Data symbol (Walsh codeword number) |
| symReady | output | 1 | The offered symbol is taken on this edge |
| chipOut | output | 1 | Current chip value |
| chipIsQ | output | 1 | 1 when `chipOut` is a Q chip, 0 when it is an I chip |
| preambleOn | output | 1 | The preamble is in progress; data source timing enable |

## Verification
At the end of a frame, several things happen on one clock edge: a new symbol is accepted, the rate and sync bit are latched, and the pilot register restarts. The first chip after that edge must reflect all of them together. The bench uses a free-running pseudo-random pattern for `rateSel` and `syncIn`, a symbol counter that cycles through all 16 codewords, and a `symValid` that drops on every seventh offer. This makes frame edges occur where the rate flips while no symbol is offered, and where the mid-frame accept of the fast rate follows a rate change. Every chip of every cycle is compared with a value the bench computes from the frame state it latched itself at each `symReady`.

// File: rtl/walsh_enc_pkg.sv
package walsh_enc_pkg;
  localparam int SLOT_W    = 7;
  localparam int FRAME_LEN = 64;
  localparam int CHIP_W    = 6;
  localparam int SYM_W     = 4;
  localparam int PN_W      = 6;

  typedef struct packed {
    logic              isQ;
    logic              inPre;
    logic              load;
    logic              frameLoad;
    logic              stepPn;
    logic [SLOT_W-1:0] slot;
  } ctrlStrobe_t;
endpackage

// File: rtl/walsh_spread_ctrl.sv
module walsh_spread_ctrl
  import walsh_enc_pkg::*;
#(
  parameter int ALT_LEN  = 32,
  parameter int WORD_LEN = 48
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rateLat,
  output ctrlStrobe_t strobe
);
  localparam logic [SLOT_W-1:0] PRE_LAST   = SLOT_W'(ALT_LEN + WORD_LEN - 1);
  localparam logic [SLOT_W-1:0] FRAME_LAST = SLOT_W'(FRAME_LEN - 1);
  localparam logic [SLOT_W-1:0] HALF_LAST  = SLOT_W'(FRAME_LEN / 2 - 1);

  logic              phase;
  logic              inPre;
  logic [SLOT_W-1:0] slot;
  logic              lastSlot;
  logic              halfEnd;

  always_comb begin
    lastSlot = inPre ? (slot == PRE_LAST) : (slot == FRAME_LAST);
    halfEnd  = !inPre && rateLat && (slot == HALF_LAST);
    strobe.isQ       = phase;
    strobe.inPre     = inPre;
    strobe.load      = phase && (lastSlot || halfEnd);
    strobe.frameLoad = phase && lastSlot;
    strobe.stepPn    = phase && !inPre;
    strobe.slot      = slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      inPre <= 1'b1;
      slot  <= '0;
    end else begin
      phase <= !phase;
      if (phase) begin
        if (lastSlot) begin
          slot  <= '0;
          inPre <= 1'b0;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/walsh_spread_dp.sv
module walsh_spread_dp
  import walsh_enc_pkg::*;
#(
  parameter int              ALT_LEN   = 32,
  parameter int              WORD_LEN  = 48,
  parameter logic [WORD_LEN-1:0] SYNC_WORD = 48'hF3A6_0D95_7C21,
  parameter logic [PN_W-1:0] PN_SEED   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic             rateSel,
  input  logic             syncIn,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symData,
  output logic             rateLat,
  output logic             chipOut
);
  localparam int IDX_W = 2 + SYM_W + CHIP_W;
  localparam int WIDX_W = $clog2(WORD_LEN);

  logic [SYM_W-1:0] sym;
  logic             syncLat;
  logic [PN_W-1:0]  pn;
  logic [CHIP_W-1:0] k;
  logic             pnBit;
  logic [IDX_W-1:0] lookupIdx;
  logic [1:0]       pairIQ;
  logic [SLOT_W-1:0] wOff;
  logic [WIDX_W-1:0] wIdx;
  logic             preBit;

  // Chip-pair lookup: index = {rate, sync, symbol, chip slot}; returns {I, Q}.
  function automatic logic [1:0] codePair(input logic [IDX_W-1:0] idx, input logic pb);
    logic             r;
    logic             s;
    logic [SYM_W-1:0] n;
    logic [CHIP_W-1:0] kk;
    logic             q;
    {r, s, n, kk} = idx;
    q = r ? ^(n & kk[4:1]) : ^(n & kk[5:2]);
    return {s ^ pb, q};
  endfunction

  always_comb begin
    k         = strobe.slot[CHIP_W-1:0];
    pnBit     = (k == CHIP_W'(FRAME_LEN - 1)) ? 1'b0 : pn[PN_W-1];
    lookupIdx = {rateLat, syncLat, sym, k};
    pairIQ    = codePair(lookupIdx, pnBit);
    wOff      = strobe.slot - SLOT_W'(ALT_LEN);
    wIdx      = WIDX_W'(WORD_LEN - 1) - WIDX_W'(wOff);
    preBit    = (strobe.slot < SLOT_W'(ALT_LEN)) ? strobe.slot[0] : SYNC_WORD[wIdx];
    if (strobe.inPre)   chipOut = strobe.isQ ? 1'b0 : preBit;
    else                chipOut = strobe.isQ ? pairIQ[0] : pairIQ[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym     <= '0;
      syncLat <= 1'b0;
      rateLat <= 1'b0;
      pn      <= PN_SEED;
    end else begin
      if (strobe.load) sym <= symValid ? symData : '0;
      if (strobe.frameLoad) begin
        syncLat <= syncIn;
        rateLat <= rateSel;
        pn      <= PN_SEED;
      end else if (strobe.stepPn) begin
        pn <= {pn[PN_W-2:0], pn[PN_W-1] ^ pn[PN_W-2]};
      end
    end
  end
endmodule

// File: rtl/walsh_spread_enc.sv
module walsh_spread_enc
  import walsh_enc_pkg::*;
#(
  parameter int                  ALT_LEN   = 32,
  parameter int                  WORD_LEN  = 48,
  parameter logic [WORD_LEN-1:0] SYNC_WORD = 48'hF3A6_0D95_7C21,
  parameter logic [PN_W-1:0]     PN_SEED   = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rateSel,
  input  logic             syncIn,
  input  logic             symValid,
  input  logic [SYM_W-1:0] symData,
  output logic             symReady,
  output logic             chipOut,
  output logic             chipIsQ,
  output logic             preambleOn
);
  ctrlStrobe_t strobe;
  logic        rateLat;

  walsh_spread_ctrl #(.ALT_LEN(ALT_LEN), .WORD_LEN(WORD_LEN)) ctrl_i (
    .clk(clk), .rst(rst), .rateLat(rateLat), .strobe(strobe)
  );

  walsh_spread_dp #(
    .ALT_LEN(ALT_LEN), .WORD_LEN(WORD_LEN), .SYNC_WORD(SYNC_WORD), .PN_SEED(PN_SEED)
  ) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe), .rateSel(rateSel), .syncIn(syncIn),
    .symValid(symValid), .symData(symData), .rateLat(rateLat), .chipOut(chipOut)
  );

  assign symReady   = strobe.load;
  assign chipIsQ    = strobe.isQ;
  assign preambleOn = strobe.inPre;
endmodule

// File: rtl/walsh_spread_chk.sv
module walsh_spread_chk (
  input logic clk,
  input logic rst,
  input logic symReady,
  input logic chipOut,
  input logic chipIsQ,
  input logic preambleOn,
  input logic rateLat
);
  p_alt_to_q_r2: assert property (@(posedge clk) disable iff (rst) !chipIsQ |=> chipIsQ);
  p_alt_to_i_r2: assert property (@(posedge clk) disable iff (rst) chipIsQ |=> !chipIsQ);
  p_ready_in_q_r7: assert property (@(posedge clk) disable iff (rst) symReady |-> chipIsQ);
  p_pre_q_zero_r3: assert property (@(posedge clk) disable iff (rst) (preambleOn && chipIsQ) |-> !chipOut);
  p_pre_ends_r3: assert property (@(posedge clk) disable iff (rst) (preambleOn && symReady) |=> !preambleOn);
  p_pre_stays_off_r3: assert property (@(posedge clk) disable iff (rst) !preambleOn |=> !preambleOn);
  p_rate_held_r8: assert property (@(posedge clk) disable iff (rst) !symReady |=> $stable(rateLat));
endmodule

bind walsh_spread_enc walsh_spread_chk chk_i (
  .clk(clk), .rst(rst), .symReady(symReady), .chipOut(chipOut),
  .chipIsQ(chipIsQ), .preambleOn(preambleOn), .rateLat(rateLat)
);

// File: tb/walsh_spread_enc_tb_top.sv
`timescale 1ns/100ps
module walsh_spread_enc_tb_top;
  localparam logic [47:0] SYNC_W = 48'hF3A6_0D95_7C21;
  localparam int FRAMES = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rateSel = 1'b0;
  logic syncIn = 1'b0;
  logic symValid = 1'b0;
  logic [3:0] symData = 4'd0;
  logic symReady, chipOut, chipIsQ, preambleOn;

  int nTests = 0;
  int nFail = 0;
  int c = 0;
  bit done = 1'b0;
  logic mseq [64];

  always #2.5 clk = !clk;

  walsh_spread_enc dut_i (
    .clk(clk), .rst(rst), .rateSel(rateSel), .syncIn(syncIn), .symValid(symValid),
    .symData(symData), .symReady(symReady), .chipOut(chipOut), .chipIsQ(chipIsQ),
    .preambleOn(preambleOn)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s cycle %0d: actual %0b expected %0b", req, c, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [5:0] s;
    logic [15:0] lf;
    logic mRate, mSync;
    logic [3:0] mSym;
    int symCnt, offerCnt;
    s = 6'h3F;
    for (int j = 0; j < 63; j++) begin
      mseq[j] = s[5];
      s = {s[4:0], s[5] ^ s[4]};
    end
    mseq[63] = 1'b0;
    lf = 16'hACE1; mRate = 0; mSync = 0; mSym = 0; symCnt = 0; offerCnt = 0;

    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 preambleOn", preambleOn, 1'b1);
    chk("R1 chipIsQ", chipIsQ, 1'b0);
    chk("R1 chipOut", chipOut, 1'b0);
    chk("R1 symReady", symReady, 1'b0);
    rst = 1'b0;

    for (c = 0; c < 160 + 128 * FRAMES; c++) begin
      int slot, ph, r;
      bit isPre, frameEnd;
      logic expBit, expReady;
      logic [5:0] k;
      isPre = (c < 160);
      if (isPre) begin
        slot = c / 2; ph = c % 2; r = 0;
        expBit = ph ? 1'b0 : ((slot < 32) ? 1'(slot % 2) : SYNC_W[47 - (slot - 32)]);
        expReady = (c == 159);
        frameEnd = (c == 159);
        chk("R3 preamble chip", chipOut, expBit);
      end else begin
        r = (c - 160) % 128; slot = r / 2; ph = r % 2;
        k = 6'(slot);
        if (ph == 0) begin
          expBit = mSync ^ mseq[slot];
          chk("R4 R8 I chip", chipOut, expBit);
        end else begin
          expBit = mRate ? ^(mSym & k[4:1]) : ^(mSym & k[5:2]);
          chk(mRate ? "R6 fast Q chip" : "R5 slow Q chip", chipOut, expBit);
        end
        expReady = (ph == 1) && (slot == 63 || (mRate && slot == 31));
        frameEnd = (r == 127);
      end
      chk("R2 chipIsQ", chipIsQ, 1'(ph));
      chk("R3 preambleOn", preambleOn, 1'(isPre));
      chk("R7 symReady", symReady, expReady);

      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rateSel = lf[3];
      syncIn = lf[9];
      symValid = (offerCnt % 7) != 3;
      symData = 4'(symCnt);
      if (expReady) begin
        mSym = symValid ? symData : 4'd0;
        if (symValid) symCnt++;
        offerCnt++;
        if (frameEnd) begin
          mRate = rateSel;
          mSync = syncIn;
        end
      end
      @(negedge clk);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule